// File: doc/BRIEF.md
# Direction and Serial Clock Source Controller

This controller sits beside a combined serializer/deserializer and decides which half of the link is live. A direction pin selects the half: high for transmit (serializer), low for receive (deserializer). A two-bit mode input selects standby, the normal rates, or the half-rate setting. The controller turns these pins into an enable for each half. It also drives a flag that forces the received word clock high whenever the receive half is off.

The controller also chooses where the serial bit clock comes from. After a power-on reset with the reference input low, the bit clock comes from an external free-running input. A detector watches the reference clock as an asynchronous signal. It synchronizes that signal through a flop chain and counts its rising edges inside fixed windows of the local clock. When enough edges fall into one window, the controller commits to the reference-derived bit clock. That choice is one-way. Neither a stopped reference nor any later traffic clears it. Only another power-on reset with the reference low returns the controller to the external clock.

All selections that change the output behaviour are applied only on a cycle flagged as a word boundary. The downstream datapath therefore never sees a mode change part way through a word.

Top module: `dirclk_mode_ctrl`

## Requirements
- R1: With the applied direction high and the applied mode non-zero, serEn is 1, desEn is 0 and wordClkHigh is 1.
- R2: With the applied direction low and the applied mode non-zero, desEn is 1, serEn is 0 and wordClkHigh is 0.
- R3: Applied mode 2'b00 is standby, with serEn and desEn both 0 and wordClkHigh 1. halfRate is 1 exactly when the applied mode is 2'b11.
- R4: dirSel and modeSel are taken up only at a rising clock edge where wordBoundary is 1. The outputs reflect them from the following cycle, and at any other edge serEn, desEn, wordClkHigh and halfRate hold their values.
- R5: While rstN is low, each edge loads dirSel, modeSel and the raw reference level directly into the applied state. After a reset whose last edge saw refRaw at 0, clkSrcRef is 0 (external bit clock).
- R6: Reference activity is detected when at least EDGE_MIN rising edges of refRaw fall within one WIN_LEN-cycle window, counted after a SYNC_STAGES-flop synchronizer. A reference that produces fewer edges per window is never detected.
- R7: Detection latches a pending reference choice. clkSrcRef rises only in the cycle after an edge where wordBoundary is 1.
- R8: Once clkSrcRef is 1 it stays 1 until the next reset, even if refRaw stops.
- R9: A reset whose last edge saw refRaw at 1 leaves clkSrcRef at 1 straight after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock for the detector and control logic |
| rstN | input | 1 | Active-low power-on reset, synchronous |
| dirSel | input | 1 | Direction pin: 1 selects serializer, 0 selects deserializer |
| modeSel | input | 2 | Mode pins: 00 standby, 01/10 full rate, 11 half rate |
| refRaw | input | 1 | Reference clock, sampled as an asynchronous level |
| wordBoundary | input | 1 | High in a cycle that ends a word; pending changes apply here |
| serEn | output | 1 | Enables the serializer half |
| desEn | output | 1 | Enables the deserializer half |
| wordClkHigh | output | 1 | Forces the received word clock high |
| halfRate | output | 1 | Selects the reference-divided-by-two serial rate |
| clkSrcRef | output | 1 | 1 = bit clock derived from reference, 0 = external bit clock |

## Verification
The assertions check the fixed relations among the outputs on every cycle: the two halves are never both enabled, the word clock flag tracks the receive enable, outputs hold between word boundaries, the clock source never drops once set, and the clock source only rises just after a boundary. Some behaviour can only be shown by the bench's scenarios. These are whether a reference that is too slow for the window is correctly ignored, whether a fast one is caught after the synchronizer delay, and whether the level of the reference during reset picks the clock source that comes out of reset. The bench covers these by comparing against its own cycle model.

// File: rtl/dirclk_pkg.sv
package dirclk_pkg;
  typedef struct packed {
    logic refHit;    // enough reference edges seen in the current window
    logic applyNow;  // word boundary: commit pending selections
  } ctrlStrobe_t;

  localparam logic [1:0] MODE_STANDBY = 2'b00;
  localparam logic [1:0] MODE_HALF    = 2'b11;
endpackage

// File: rtl/dirclk_detect.sv
module dirclk_detect
  import dirclk_pkg::*;
#(
  parameter int WIN_LEN     = 16,
  parameter int EDGE_MIN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        refRaw,
  input  logic        wordBoundary,
  output ctrlStrobe_t strb
);
  localparam int WIN_W = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
  localparam int CNT_W = (EDGE_MIN > 2) ? $clog2(EDGE_MIN) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(EDGE_MIN - 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   refSync;
  logic                   refPrev;
  logic                   refRise;
  logic [WIN_W-1:0]       winCnt;
  logic [CNT_W-1:0]       edgeCnt;
  logic                   winEnd;
  logic                   hit;

  // Synchronizer chain; depth selected by parameter
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= refRaw;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], refRaw};
      end
    end
  endgenerate

  assign refSync = syncChain[SYNC_STAGES-1];
  assign refRise = refSync & ~refPrev;
  assign winEnd  = (winCnt == WIN_LAST);
  assign hit     = refRise && (edgeCnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refPrev <= 1'b0;
      winCnt  <= '0;
      edgeCnt <= '0;
    end else begin
      refPrev <= refSync;
      if (winEnd) begin
        winCnt  <= '0;
        edgeCnt <= '0;
      end else begin
        winCnt <= winCnt + WIN_W'(1);
        if (refRise && (edgeCnt != CNT_LAST))
          edgeCnt <= edgeCnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    strb.refHit   = hit;
    strb.applyNow = wordBoundary;
  end
endmodule

// File: rtl/dirclk_state.sv
module dirclk_state
  import dirclk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        dirSel,
  input  logic [1:0]  modeSel,
  input  logic        refRaw,
  input  ctrlStrobe_t strb,
  output logic        serEn,
  output logic        desEn,
  output logic        wordClkHigh,
  output logic        halfRate,
  output logic        clkSrcRef
);
  logic       refLatched;
  logic       srcReg;
  logic       dirReg;
  logic [1:0] modeReg;
  logic       active;

  // Reset loads pins directly; the reference level at reset picks the source
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refLatched <= refRaw;
      srcReg     <= refRaw;
      dirReg     <= dirSel;
      modeReg    <= modeSel;
    end else begin
      if (strb.refHit) refLatched <= 1'b1;
      if (strb.applyNow) begin
        srcReg  <= srcReg | refLatched | strb.refHit;
        dirReg  <= dirSel;
        modeReg <= modeSel;
      end
    end
  end

  assign active      = (modeReg != MODE_STANDBY);
  assign serEn       = active & dirReg;
  assign desEn       = active & ~dirReg;
  assign wordClkHigh = ~desEn;
  assign halfRate    = (modeReg == MODE_HALF);
  assign clkSrcRef   = srcReg;
endmodule

// File: rtl/dirclk_mode_ctrl.sv
module dirclk_mode_ctrl
  import dirclk_pkg::*;
#(
  parameter int WIN_LEN     = 16,
  parameter int EDGE_MIN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dirSel,
  input  logic [1:0] modeSel,
  input  logic       refRaw,
  input  logic       wordBoundary,
  output logic       serEn,
  output logic       desEn,
  output logic       wordClkHigh,
  output logic       halfRate,
  output logic       clkSrcRef
);
  ctrlStrobe_t strb;

  dirclk_detect #(
    .WIN_LEN    (WIN_LEN),
    .EDGE_MIN   (EDGE_MIN),
    .SYNC_STAGES(SYNC_STAGES)
  ) uDetect (
    .clk         (clk),
    .rstN        (rstN),
    .refRaw      (refRaw),
    .wordBoundary(wordBoundary),
    .strb        (strb)
  );

  dirclk_state uState (
    .clk        (clk),
    .rstN       (rstN),
    .dirSel     (dirSel),
    .modeSel    (modeSel),
    .refRaw     (refRaw),
    .strb       (strb),
    .serEn      (serEn),
    .desEn      (desEn),
    .wordClkHigh(wordClkHigh),
    .halfRate   (halfRate),
    .clkSrcRef  (clkSrcRef)
  );
endmodule

// File: rtl/dirclk_mode_ctrl_chk.sv
module dirclk_mode_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic wordBoundary,
  input logic serEn,
  input logic desEn,
  input logic wordClkHigh,
  input logic halfRate,
  input logic clkSrcRef
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  a_r1_ser_excludes_des: assert property (@(posedge clk) disable iff (!rstN)
    serEn |-> (!desEn && wordClkHigh));

  a_r2_des_drops_wordclk: assert property (@(posedge clk) disable iff (!rstN)
    desEn |-> (!serEn && !wordClkHigh));

  a_r3_standby_forces_high: assert property (@(posedge clk) disable iff (!rstN)
    (!serEn && !desEn) |-> wordClkHigh);

  a_r4_hold_between_words: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !wordBoundary) |=> $stable({serEn, desEn, wordClkHigh, halfRate}));

  a_r7_source_rises_at_word: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $rose(clkSrcRef)) |-> $past(wordBoundary));

  a_r8_source_sticky: assert property (@(posedge clk) disable iff (!rstN)
    clkSrcRef |=> clkSrcRef);
endmodule

bind dirclk_mode_ctrl dirclk_mode_ctrl_chk uChk (
  .clk         (clk),
  .rstN        (rstN),
  .wordBoundary(wordBoundary),
  .serEn       (serEn),
  .desEn       (desEn),
  .wordClkHigh (wordClkHigh),
  .halfRate    (halfRate),
  .clkSrcRef   (clkSrcRef)
);

// File: tb/dirclk_mode_ctrl_test.sv
`timescale 1ns/1ps
module dirclk_mode_ctrl_test;
  localparam int WIN = 16;
  localparam int EMIN = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dirSel = 1'b1;
  logic [1:0] modeSel = 2'b01;
  logic refRaw = 1'b0;
  logic wordBoundary = 1'b0;
  logic serEn, desEn, wordClkHigh, halfRate, clkSrcRef;

  int checks = 0;
  int fails = 0;
  string curTag = "R5";
  bit running = 1'b0;
  bit done = 1'b0;

  int refHalf = 0;
  logic refLevel = 1'b0;
  int refCnt = 0;
  int wbEvery = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  dirclk_mode_ctrl #(.WIN_LEN(WIN), .EDGE_MIN(EMIN), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .dirSel(dirSel), .modeSel(modeSel),
    .refRaw(refRaw), .wordBoundary(wordBoundary), .serEn(serEn),
    .desEn(desEn), .wordClkHigh(wordClkHigh), .halfRate(halfRate),
    .clkSrcRef(clkSrcRef)
  );

  // Reference clock and word boundary generators
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (refHalf == 0) begin
      refRaw <= refLevel;
      refCnt <= 0;
    end else if (refCnt == refHalf - 1) begin
      refRaw <= ~refRaw;
      refCnt <= 0;
    end else begin
      refCnt <= refCnt + 1;
    end
    wordBoundary <= (wbEvery != 0) && ((cyc % wbEvery) == wbEvery - 1);
  end

  // Behavioural reference model
  int  mq[$];
  int  mWin, mCnt;
  bit  mLatched, mSrc, mDir;
  int  mMode;
  always @(posedge clk) begin
    if (!rstN) begin
      mq = '{0, 0, 0, 0};
      mWin = 0; mCnt = 0;
      mLatched = refRaw; mSrc = refRaw;
      mDir = dirSel; mMode = int'(modeSel);
    end else begin
      mq.push_back(int'(refRaw));
      void'(mq.pop_front());
      if (mq[1] == 1 && mq[0] == 0) mCnt++;
      if (mCnt >= EMIN) mLatched = 1;
      if (mWin == WIN - 1) begin mWin = 0; mCnt = 0; end
      else mWin++;
      if (wordBoundary) begin
        if (mLatched) mSrc = 1;
        mDir = dirSel;
        mMode = int'(modeSel);
      end
    end
  end

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (running && rstN) begin
      bit act;
      act = (mMode != 0);
      check(curTag, serEn,       act && mDir,            "serEn");
      check(curTag, desEn,       act && !mDir,           "desEn");
      check(curTag, wordClkHigh, !(act && !mDir),        "wordClkHigh");
      check(curTag, halfRate,    mMode == 3,             "halfRate");
      check(curTag, clkSrcRef,   mSrc,                   "clkSrcRef");
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset(input logic lvl);
    refHalf = 0; refLevel = lvl;
    waitCyc(2);
    rstN = 1'b0;
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(1);
  endtask

  initial begin
    waitCyc(5);
    rstN = 1'b1;
    running = 1'b1;
    waitCyc(1);
    // R5: reset state with reference low
    check("R5", clkSrcRef, 1'b0, "clkSrcRef after reset");
    check("R1", serEn, 1'b1, "serEn after reset dir=1");
    check("R1", wordClkHigh, 1'b1, "wordClkHigh in serializer mode");

    // R4: pins ignored without a word boundary
    curTag = "R4";
    dirSel = 1'b0; modeSel = 2'b10;
    waitCyc(12);
    check("R4", serEn, 1'b1, "serEn held without boundary");
    check("R4", desEn, 1'b0, "desEn held without boundary");

    // R2: apply at boundary
    curTag = "R2";
    wbEvery = 8;
    waitCyc(12);
    check("R2", desEn, 1'b1, "desEn after boundary");
    check("R2", wordClkHigh, 1'b0, "wordClkHigh in deserializer mode");

    // R3: standby and half rate
    curTag = "R3";
    modeSel = 2'b00;
    waitCyc(12);
    check("R3", serEn | desEn, 1'b0, "both halves off in standby");
    check("R3", wordClkHigh, 1'b1, "wordClkHigh in standby");
    modeSel = 2'b11; dirSel = 1'b1;
    waitCyc(12);
    check("R3", halfRate, 1'b1, "halfRate with mode 11");
    check("R1", serEn, 1'b1, "serEn in half rate mode");
    modeSel = 2'b01;
    waitCyc(12);
    check("R3", halfRate, 1'b0, "halfRate with mode 01");

    // R6: slow reference never detected
    curTag = "R6";
    refHalf = 10;
    waitCyc(120);
    check("R6", clkSrcRef, 1'b0, "slow reference ignored");

    // R7: fast reference detected, held until a boundary
    curTag = "R7";
    wbEvery = 0;
    refHalf = 1;
    waitCyc(40);
    check("R7", clkSrcRef, 1'b0, "no switch before boundary");
    wbEvery = 8;
    waitCyc(12);
    check("R6", clkSrcRef, 1'b1, "fast reference detected");

    // R8: reference stops, choice sticks
    curTag = "R8";
    refHalf = 0; refLevel = 1'b0;
    waitCyc(100);
    check("R8", clkSrcRef, 1'b1, "source sticky after reference stops");

    // R5: reset with reference low returns to external clock
    curTag = "R5";
    doReset(1'b0);
    check("R5", clkSrcRef, 1'b0, "external source after reset with ref low");
    waitCyc(20);

    // R9: reset with reference high leaves reference mode
    curTag = "R9";
    doReset(1'b1);
    check("R9", clkSrcRef, 1'b1, "reference source after reset with ref high");
    waitCyc(20);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule